// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block produces the status byte and the ready/busy line that a NOR-style flash controller presents to the host while an internal program or erase operation is running. A command decoder, which is not part of this block, reports each finished command sequence as a single-cycle command strobe carrying an operation code, a target sector and bit 7 of the program data. An internal timing engine, also not part of this block, reports the end of an operation with a one-cycle `op_done` pulse. The block tracks the operating mode, the set of sectors selected for erase, and the sector-erase timer window. It decides which commands are accepted, and on every host read strobe it latches either the true array data or a status byte whose toggle bits change on successive reads.

The mode machine has six states. `ST_IDLE` is ready, and reads return array data. `ST_PROG` is an ordinary program. `ST_ERASE_WIN` means sector-erase commands are being gathered and the window timer is running. `ST_ERASE` means the erase is running. `ST_SUSP_RD` is erase suspended with reads allowed. `ST_SUSP_PROG` is a program issued while an erase is suspended. The transitions are as follows:
- IDLE to PROG on a program command.
- IDLE to ERASE_WIN on a sector-erase command.
- PROG to IDLE on done.
- ERASE_WIN stays in ERASE_WIN on a further sector-erase command, which reloads the timer.
- ERASE_WIN to ERASE when the timer expires.
- ERASE_WIN to SUSP_RD on suspend.
- ERASE to IDLE on done.
- ERASE to SUSP_RD on suspend.
- SUSP_RD to ERASE on resume.
- SUSP_RD to SUSP_PROG on a program command aimed at a sector not selected for erase.
- SUSP_PROG to SUSP_RD on done.

Top module: `nor_status_gen`

## Requirements
- R1: While `rst_n` is low, `ready` is 0. After reset the mode is idle, `rd_data` is 0 and both toggle bits are 0, so the first status read of a program shows bit 6 = 0.
- R2: In program mode a status read returns bit 7 = inverse of the latched program bit 7, bit 6 = the any-operation toggle, bit 2 = 1, and all other bits 0. `op_done` returns the block to idle, where each read latches `array_data`.
- R3: While the erase runs (window closed), a read returns bit 7 = 0, bit 6 = the any-operation toggle, bit 3 = 1, and bit 2 = the sector toggle. All other bits are 0.
- R4: In erase-suspend-read mode, a read of a sector selected for erase returns bit 7 = 1, bit 6 = 1 (steady), bit 3 = 0 and bit 2 = the sector toggle. A read of any other sector latches `array_data`. `ready` is 1.
- R5: In erase-suspend-program mode a read returns bit 7 = inverse of the latched bit 7, bit 6 = the toggle, bit 2 = 1, and other bits 0. `ready` is 0, and `op_done` returns the block to erase-suspend-read.
- R6: A sector-erase command adds its sector to the erase mask and reloads the window counter with `WIN_CYC`. While the window is open, bit 3 reads 0. The erase starts (bit 3 = 1) WIN_CYC+1 cycles after the last accepted sector-erase command. Suspend is also accepted in the window.
- R7: Commands are `cmd_op` 0 = program, 1 = sector erase, 2 = suspend, 3 = resume. Any command that does not match the accepted set of the current mode is ignored: no acknowledge and no change of mode or mask. In particular, every command is ignored while programming, and only suspend is accepted while the erase runs.
- R8: `ready` is 1 exactly in idle and erase-suspend-read with `rst_n` high, and 0 otherwise.
- R9: `cmd_ack` pulses for one cycle, in the cycle after the edge at which a command was accepted.
- R10: A read strobe is a rising edge of `rd_en`. `rd_data` changes only at a strobe. The any-operation toggle inverts on each strobe in program, window, erase and suspend-program modes. The sector toggle inverts on each strobe in window, erase and suspend-read modes when `rd_sector` is in the erase mask. Holding `rd_en` high gives no further strobes.
- R11: In erase-suspend-read, resume returns the block to the running erase (bit 3 = 1), and a program aimed at a sector in the erase mask is ignored.
- R12: `op_done` during the running erase returns the block to idle and clears the mask. It takes priority over a suspend in the same cycle. `op_done` in idle, window or suspend-read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a completed command sequence |
| cmd_op | input | 2 | Command code (0 program, 1 sector erase, 2 suspend, 3 resume) |
| cmd_sector | input | SECT_W | Sector addressed by the command |
| cmd_bit7 | input | 1 | Bit 7 of the data being programmed |
| op_done | input | 1 | Internal operation finished |
| rd_en | input | 1 | Host read enable; a rising edge is a read strobe |
| rd_sector | input | SECT_W | Sector field of the read address |
| array_data | input | DATA_W | True array contents at the read address |
| ready | output | 1 | 1 = ready, 0 = busy |
| cmd_ack | output | 1 | Command accepted (one cycle, delayed) |
| rd_data | output | DATA_W | Byte latched at the last read strobe |

## Verification
The bench checks the following corner cases:
- **Window reload.** It re-issues a sector erase just before the window would close. A counter that is not reloaded would raise bit 3 too early.
- **Suspended-sector reads.** It reads suspended and non-suspended sectors alternately. A design that compared against the wrong mask would toggle bit 2 on the wrong sector or return status where array data belongs.
- **Reads during a held `rd_en`.** It holds `rd_en` high for several cycles. A level-sensitive toggle would keep flipping and change `rd_data`.
- **Done and suspend together.** It drives `op_done` and suspend in the same cycle. Wrong priority would leave the block stuck suspended with a stale mask.
- **Ignored commands.** It drives commands that must be ignored, in every mode. A leaky accept would raise `cmd_ack` or move the mode.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE_WIN = 3'd2,
        ST_ERASE     = 3'd3,
        ST_SUSP_RD   = 3'd4,
        ST_SUSP_PROG = 3'd5
    } nsg_state_e;

    typedef enum logic [1:0] {
        OP_PROGRAM    = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_SUSPEND    = 2'd2,
        OP_RESUME     = 2'd3
    } nsg_op_e;

    // status byte bit positions the host decodes
    localparam int unsigned BIT_POLL     = 7;
    localparam int unsigned BIT_TOG_ANY  = 6;
    localparam int unsigned BIT_WINDOW   = 3;
    localparam int unsigned BIT_TOG_SECT = 2;

endpackage

// File: rtl/nsg_mode_fsm.sv
module nsg_mode_fsm
    import nsg_pkg::*;
#(
    parameter int unsigned NUM_SECT = 32,
    parameter int unsigned WIN_CYC  = 40,
    localparam int unsigned SECT_W  = $clog2(NUM_SECT),
    localparam int unsigned CNT_W   = $clog2(WIN_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [SECT_W-1:0]   cmd_sector,
    input  logic                cmd_bit7,
    input  logic                op_done,
    output nsg_state_e          st_q,
    output logic [NUM_SECT-1:0] mask_q,
    output logic                bit7_q,
    output logic                cmd_ack
);

    nsg_state_e          st_d;
    logic [NUM_SECT-1:0] mask_d;
    logic [NUM_SECT-1:0] sect_onehot;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                bit7_d;
    logic                accept;
    logic                is_prog, is_erase, is_susp, is_resume;

    assign is_prog     = cmd_valid && (nsg_op_e'(cmd_op) == OP_PROGRAM);
    assign is_erase    = cmd_valid && (nsg_op_e'(cmd_op) == OP_SECT_ERASE);
    assign is_susp     = cmd_valid && (nsg_op_e'(cmd_op) == OP_SUSPEND);
    assign is_resume   = cmd_valid && (nsg_op_e'(cmd_op) == OP_RESUME);
    assign sect_onehot = NUM_SECT'(1) << cmd_sector;

    // next-state and acceptance decision
    always_comb begin
        st_d   = st_q;
        mask_d = mask_q;
        cnt_d  = cnt_q;
        bit7_d = bit7_q;
        accept = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (is_prog) begin
                    st_d   = ST_PROG;
                    bit7_d = cmd_bit7;
                    accept = 1'b1;
                end else if (is_erase) begin
                    st_d   = ST_ERASE_WIN;
                    mask_d = sect_onehot;
                    cnt_d  = CNT_W'(WIN_CYC);
                    accept = 1'b1;
                end
            end
            ST_PROG: begin
                if (op_done) st_d = ST_IDLE;
            end
            ST_ERASE_WIN: begin
                if (is_susp) begin
                    st_d   = ST_SUSP_RD;
                    accept = 1'b1;
                end else if (is_erase) begin
                    mask_d = mask_q | sect_onehot;
                    cnt_d  = CNT_W'(WIN_CYC);
                    accept = 1'b1;
                end else if (cnt_q == '0) begin
                    st_d = ST_ERASE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ERASE: begin
                if (op_done) begin
                    st_d   = ST_IDLE;
                    mask_d = '0;
                end else if (is_susp) begin
                    st_d   = ST_SUSP_RD;
                    accept = 1'b1;
                end
            end
            ST_SUSP_RD: begin
                if (is_resume) begin
                    st_d   = ST_ERASE;
                    accept = 1'b1;
                end else if (is_prog && !mask_q[cmd_sector]) begin
                    st_d   = ST_SUSP_PROG;
                    bit7_d = cmd_bit7;
                    accept = 1'b1;
                end
            end
            ST_SUSP_PROG: begin
                if (op_done) st_d = ST_SUSP_RD;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mask_q <= '0;
            cnt_q  <= '0;
            bit7_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
            cnt_q  <= cnt_d;
            bit7_q <= bit7_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_ack <= 1'b0;
        else        cmd_ack <= accept;
    end

endmodule

// File: rtl/nsg_toggle_pair.sv
module nsg_toggle_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic any_cond,
    input  logic sect_cond,
    output logic strobe,
    output logic tog_any_q,
    output logic tog_sect_q
);

    logic rd_prev_q;

    assign strobe = rd_en && !rd_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_q  <= 1'b0;
            tog_any_q  <= 1'b0;
            tog_sect_q <= 1'b0;
        end else begin
            rd_prev_q <= rd_en;
            if (strobe && any_cond)  tog_any_q  <= !tog_any_q;
            if (strobe && sect_cond) tog_sect_q <= !tog_sect_q;
        end
    end

endmodule

// File: rtl/nsg_read_mux.sv
module nsg_read_mux
    import nsg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  nsg_state_e        st,
    input  logic              sect_hit,
    input  logic              bit7,
    input  logic              tog_any,
    input  logic              tog_sect,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] status;

    always_comb begin
        status = '0;
        unique case (st)
            ST_IDLE: status = array_data;
            ST_PROG, ST_SUSP_PROG: begin
                status[BIT_POLL]     = !bit7;
                status[BIT_TOG_ANY]  = tog_any;
                status[BIT_TOG_SECT] = 1'b1;
            end
            ST_ERASE_WIN, ST_ERASE: begin
                status[BIT_TOG_ANY]  = tog_any;
                status[BIT_WINDOW]   = (st == ST_ERASE);
                status[BIT_TOG_SECT] = tog_sect;
            end
            ST_SUSP_RD: begin
                if (sect_hit) begin
                    status[BIT_POLL]     = 1'b1;
                    status[BIT_TOG_ANY]  = 1'b1;
                    status[BIT_TOG_SECT] = tog_sect;
                end else begin
                    status = array_data;
                end
            end
            default: status = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (strobe) rd_data <= status;
    end

endmodule

// File: rtl/nor_status_gen.sv
module nor_status_gen
    import nsg_pkg::*;
#(
    parameter int unsigned NUM_SECT = 32,
    parameter int unsigned WIN_CYC  = 40,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned SECT_W  = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SECT_W-1:0] cmd_sector,
    input  logic              cmd_bit7,
    input  logic              op_done,
    input  logic              rd_en,
    input  logic [SECT_W-1:0] rd_sector,
    input  logic [DATA_W-1:0] array_data,
    output logic              ready,
    output logic              cmd_ack,
    output logic [DATA_W-1:0] rd_data
);

    nsg_state_e          st_q;
    logic [NUM_SECT-1:0] mask_q;
    logic                bit7_q;
    logic                strobe, tog_any, tog_sect;
    logic                sect_hit, any_cond, sect_cond;

    nsg_mode_fsm #(.NUM_SECT(NUM_SECT), .WIN_CYC(WIN_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_bit7(cmd_bit7), .op_done(op_done),
        .st_q(st_q), .mask_q(mask_q), .bit7_q(bit7_q), .cmd_ack(cmd_ack)
    );

    assign sect_hit  = mask_q[rd_sector];
    assign any_cond  = (st_q == ST_PROG) || (st_q == ST_ERASE_WIN) ||
                       (st_q == ST_ERASE) || (st_q == ST_SUSP_PROG);
    assign sect_cond = sect_hit && ((st_q == ST_ERASE_WIN) ||
                       (st_q == ST_ERASE) || (st_q == ST_SUSP_RD));
    assign ready     = rst_n && ((st_q == ST_IDLE) || (st_q == ST_SUSP_RD));

    nsg_toggle_pair u_tog (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .any_cond(any_cond),
        .sect_cond(sect_cond), .strobe(strobe), .tog_any_q(tog_any),
        .tog_sect_q(tog_sect)
    );

    nsg_read_mux #(.DATA_W(DATA_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .st(st_q),
        .sect_hit(sect_hit), .bit7(bit7_q), .tog_any(tog_any),
        .tog_sect(tog_sect), .array_data(array_data), .rd_data(rd_data)
    );

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker
    import nsg_pkg::*;
#(
    parameter int unsigned NUM_SECT = 32,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned SECT_W  = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ready,
    input logic                cmd_valid,
    input logic                cmd_ack,
    input logic                op_done,
    input logic                rd_en,
    input logic [SECT_W-1:0]   rd_sector,
    input logic [DATA_W-1:0]   rd_data,
    input nsg_state_e          st,
    input logic [NUM_SECT-1:0] mask
);

    logic rd_seen_q;
    logic stb_c;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_seen_q <= 1'b0;
        else        rd_seen_q <= rd_en;
    end
    assign stb_c = rd_en && !rd_seen_q;

    always_comb begin
        if (!rst_n) AST_BUSY_IN_RESET: assert (!ready); // R8
    end

    AST_ACK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> $past(cmd_valid)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_c |=> $stable(rd_data)); // R10
    AST_PROG_DQ2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c && st == ST_PROG) |=> rd_data[BIT_TOG_SECT]); // R2
    AST_ERASE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c && st == ST_ERASE) |=> (!rd_data[BIT_POLL] && rd_data[BIT_WINDOW])); // R3
    AST_SUSP_SECT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c && st == ST_SUSP_RD && mask[rd_sector]) |=> (rd_data[BIT_POLL] && rd_data[BIT_TOG_ANY])); // R4
    AST_SPROG_DQ2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c && st == ST_SUSP_PROG) |=> rd_data[BIT_TOG_SECT]); // R5
    AST_WINDOW_OPEN_DQ3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_c && st == ST_ERASE_WIN) |=> !rd_data[BIT_WINDOW]); // R6
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE_WIN || st == ST_ERASE || st == ST_SUSP_RD || st == ST_SUSP_PROG) |-> (mask != '0)); // R6
    AST_IGNORE_WHILE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> !cmd_ack); // R7
    AST_DONE_ENDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && op_done) |=> (st == ST_IDLE && mask == '0)); // R12

endmodule

bind nor_status_gen nsg_checker #(.NUM_SECT(NUM_SECT), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .cmd_valid(cmd_valid),
    .cmd_ack(cmd_ack), .op_done(op_done), .rd_en(rd_en), .rd_sector(rd_sector),
    .rd_data(rd_data), .st(st_q), .mask(mask_q)
);

// File: tb/nor_status_gen_test.sv
module nor_status_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 32;
    localparam int SW  = 5;
    localparam int WIN = 12;
    localparam int M_IDLE = 0, M_PROG = 1, M_WIN = 2, M_ERS = 3, M_SRD = 4, M_SPG = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [SW-1:0] cmd_sector = '0;
    logic          cmd_bit7 = 1'b0;
    logic          op_done = 1'b0;
    logic          rd_en = 1'b0;
    logic [SW-1:0] rd_sector = '0;
    logic [7:0]    array_data = 8'h00;
    logic          ready, cmd_ack;
    logic [7:0]    rd_data;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_status_gen #(.NUM_SECT(NS), .WIN_CYC(WIN), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_bit7(cmd_bit7), .op_done(op_done),
        .rd_en(rd_en), .rd_sector(rd_sector), .array_data(array_data),
        .ready(ready), .cmd_ack(cmd_ack), .rd_data(rd_data)
    );

    // behavioural reference model
    int         m_st = M_IDLE;
    bit         m_mask [NS];
    int         m_cnt = 0;
    bit         m_b7 = 0, m_t6 = 0, m_t2 = 0, m_rdq = 0, m_ack = 0;
    logic [7:0] m_rd = 8'h00;
    string      m_tag = "R1";
    bit         stb, hit, acc;

    function automatic logic [7:0] exp_status(bit h);
        logic [7:0] s = 8'h00;
        case (m_st)
            M_IDLE: s = array_data;
            M_PROG, M_SPG: begin s[7] = !m_b7; s[6] = m_t6; s[2] = 1'b1; end
            M_WIN, M_ERS: begin s[6] = m_t6; s[3] = (m_st == M_ERS); s[2] = m_t2; end
            M_SRD: if (h) begin s[7] = 1'b1; s[6] = 1'b1; s[2] = m_t2; end
                   else s = array_data;
            default: s = 8'h00;
        endcase
        return s;
    endfunction

    function automatic string tag_of(int st);
        case (st)
            M_PROG: return "R2";
            M_WIN:  return "R6";
            M_ERS:  return "R3";
            M_SRD:  return "R4";
            M_SPG:  return "R5";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_b7 = 0; m_t6 = 0; m_t2 = 0;
            m_rdq = 0; m_ack = 0; m_rd = 8'h00; m_tag = "R1";
            foreach (m_mask[i]) m_mask[i] = 0;
        end else begin
            stb = rd_en && !m_rdq;
            m_rdq = rd_en;
            hit = m_mask[rd_sector];
            if (stb) begin
                m_rd  = exp_status(hit);
                m_tag = tag_of(m_st);
                if (m_st == M_PROG || m_st == M_WIN || m_st == M_ERS || m_st == M_SPG) m_t6 = !m_t6;
                if (hit && (m_st == M_WIN || m_st == M_ERS || m_st == M_SRD)) m_t2 = !m_t2;
            end
            acc = 0;
            case (m_st)
                M_IDLE:
                    if (cmd_valid && cmd_op == 0) begin m_st = M_PROG; m_b7 = cmd_bit7; acc = 1; end
                    else if (cmd_valid && cmd_op == 1) begin
                        foreach (m_mask[i]) m_mask[i] = 0;
                        m_mask[cmd_sector] = 1; m_cnt = WIN; m_st = M_WIN; acc = 1;
                    end
                M_PROG: if (op_done) m_st = M_IDLE;
                M_WIN:
                    if (cmd_valid && cmd_op == 2) begin m_st = M_SRD; acc = 1; end
                    else if (cmd_valid && cmd_op == 1) begin m_mask[cmd_sector] = 1; m_cnt = WIN; acc = 1; end
                    else if (m_cnt == 0) m_st = M_ERS;
                    else m_cnt = m_cnt - 1;
                M_ERS:
                    if (op_done) begin m_st = M_IDLE; foreach (m_mask[i]) m_mask[i] = 0; end
                    else if (cmd_valid && cmd_op == 2) begin m_st = M_SRD; acc = 1; end
                M_SRD:
                    if (cmd_valid && cmd_op == 3) begin m_st = M_ERS; acc = 1; end
                    else if (cmd_valid && cmd_op == 0 && !m_mask[cmd_sector]) begin
                        m_st = M_SPG; m_b7 = cmd_bit7; acc = 1;
                    end
                M_SPG: if (op_done) m_st = M_SRD;
                default: m_st = M_IDLE;
            endcase
            m_ack = acc;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            check("R8 ready", ready, rst_n && (m_st == M_IDLE || m_st == M_SRD));
            if (rst_n) begin
                check("R9 cmd_ack", cmd_ack, m_ack);
                check({m_tag, " rd_data"}, rd_data, m_rd);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic send(int op, int sect, bit b7);
        @(negedge clk); #1;
        cmd_valid = 1; cmd_op = 2'(op); cmd_sector = SW'(sect); cmd_bit7 = b7;
        @(negedge clk); #1;
        cmd_valid = 0;
    endtask

    task automatic rd(int sect);
        @(negedge clk); #1;
        rd_en = 1; rd_sector = SW'(sect);
        @(negedge clk); #1;
        rd_en = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); #1; op_done = 1;
        @(negedge clk); #1; op_done = 0;
    endtask

    initial begin
        tick(5);
        check("R1 reset busy", ready, 0);
        rst_n = 1;
        tick(1);
        check("R1 rd_data after reset", rd_data, 8'h00);
        check("R8 idle ready", ready, 1);

        // idle reads
        array_data = 8'hA5; rd(2);
        check("R2 idle array read", rd_data, 8'hA5);
        array_data = 8'h3C; rd(4);
        check("R2 idle array read", rd_data, 8'h3C);

        // program, bit7 = 1
        send(0, 1, 1);
        check("R9 program ack", cmd_ack, 1);
        check("R2 busy in program", ready, 0);
        rd(1); check("R2 first program status", rd_data, 8'h04);
        rd(1); check("R2 second program status", rd_data, 8'h44);
        send(1, 3, 0); check("R7 erase ignored in program", cmd_ack, 0);
        send(2, 0, 0); check("R7 suspend ignored in program", cmd_ack, 0);
        // hold rd_en high
        @(negedge clk); #1; rd_en = 1; tick(4);
        check("R10 held read single strobe", rd_data, 8'h04);
        rd_en = 0; tick(1);
        rd(0); check("R10 next strobe toggles", rd_data, 8'h44);
        done_pulse();
        array_data = 8'h81; rd(0);
        check("R2 back to array data", rd_data, 8'h81);
        send(2, 0, 0); check("R7 suspend ignored in idle", cmd_ack, 0);

        // program, bit7 = 0
        send(0, 6, 0);
        rd(6); check("R2 poll bit with bit7=0", rd_data[7], 1);
        done_pulse();

        // sector erase with window reload
        send(1, 3, 0);
        check("R6 window busy", ready, 0);
        rd(3); check("R6 window DQ3 low", rd_data[3], 0);
        done_pulse();
        tick(WIN - 6);
        send(1, 5, 0); check("R6 second erase accepted", cmd_ack, 1);
        tick(WIN - 4);
        rd(7); check("R6 window still open after reload", rd_data[3], 0);
        rd(5); rd(5); rd(7);
        tick(WIN);
        rd(3); check("R3 erase running DQ3", rd_data[3], 1);
        rd(3); rd(9);
        send(0, 9, 1); check("R7 program ignored in erase", cmd_ack, 0);
        send(1, 9, 0); check("R7 erase ignored after window", cmd_ack, 0);

        // suspend
        send(2, 0, 0); check("R9 suspend ack", cmd_ack, 1);
        check("R4 ready in suspend", ready, 1);
        rd(3); check("R4 suspended sector poll", rd_data[7:6], 2'b11);
        rd(3); rd(5);
        array_data = 8'h5A; rd(9);
        check("R4 other sector array data", rd_data, 8'h5A);
        done_pulse();
        send(0, 5, 1); check("R11 program to suspended sector ignored", cmd_ack, 0);
        send(0, 9, 1); check("R5 suspend program ack", cmd_ack, 1);
        check("R5 busy", ready, 0);
        rd(9); rd(9); rd(3);
        check("R5 DQ2 high", rd_data[2], 1);
        done_pulse(); check("R5 back to suspend read", ready, 1);
        send(3, 0, 0); check("R11 resume ack", cmd_ack, 1);
        rd(5); check("R11 resumed erase DQ3", rd_data[3], 1);

        // done and suspend in the same cycle
        @(negedge clk); #1;
        op_done = 1; cmd_valid = 1; cmd_op = 2'd2;
        @(negedge clk); #1;
        op_done = 0; cmd_valid = 0;
        check("R12 done beats suspend", ready, 1);
        check("R12 suspend not acked", cmd_ack, 0);
        array_data = 8'h77; rd(3);
        check("R12 mask cleared", rd_data, 8'h77);

        // suspend inside the window
        send(1, 10, 0);
        send(2, 0, 0); check("R6 suspend in window", ready, 1);
        rd(10); rd(10);
        send(3, 0, 0); rd(10);
        check("R11 resume from window suspend", rd_data[3], 1);
        done_pulse();

        // random phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); #1;
            cmd_valid  = ($urandom_range(0, 5) == 0);
            cmd_op     = 2'($urandom_range(0, 3));
            cmd_sector = SW'($urandom_range(0, 7));
            cmd_bit7   = 1'($urandom_range(0, 1));
            op_done    = ($urandom_range(0, 24) == 0);
            rd_en      = 1'($urandom_range(0, 1));
            rd_sector  = SW'($urandom_range(0, 7));
            array_data = 8'($urandom_range(0, 255));
        end
        cmd_valid = 0; op_done = 0; rd_en = 0;
        tick(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule